// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a target-only two-wire serial bus endpoint (SMBus/I2C electrical convention: SCL input, open-drain SDA) that gives a host block-transfer access to a file of eight configuration bytes. The lines are resampled by the system clock, so the bus clock is never used as a clock. Both lines pass through a synchronizer and a stability filter before any edge or start/stop condition is recognized.

Each transfer names a starting register index. A write then carries a byte count and that many data bytes, which land in consecutive registers. A read re-addresses the target after a repeated start and receives the programmable readback count first, then register contents from the starting index upward. The register fields drive the output controller over plain parallel outputs: per-pair enables and slew selects, the spread controls, the swing code, and the reference-output controls. Reserved and read-only bits keep fixed values.

The protocol engine is one state machine with these states:
- IDLE: bus free.
- ADDR: shifting in the address byte.
- ADDR_ACK: the address has matched and the target drives the acknowledge.
- INDEX, INDEX_ACK: receiving and acknowledging the starting index.
- COUNT, COUNT_ACK: receiving and acknowledging the write byte count.
- WDATA, WDATA_ACK: receiving, storing and acknowledging data.
- RDATA: driving a byte.
- RDATA_ACK: sampling the host's acknowledge.
- HOLD: not addressed, or transfer refused; the target waits with SDA released.

The transitions are as follows:
- A start or repeated start moves any state to ADDR. A stop moves any state to IDLE.
- ADDR goes to ADDR_ACK on a match and to HOLD on a mismatch.
- ADDR_ACK goes to RDATA for a read and to INDEX for a write.
- INDEX_ACK goes to COUNT, and COUNT_ACK goes to WDATA.
- WDATA goes to WDATA_ACK while the count has room, and to HOLD once it is used up. WDATA_ACK returns to WDATA.
- RDATA goes to RDATA_ACK after eight bits. RDATA_ACK returns to RDATA on an acknowledge and goes to HOLD on a not-acknowledge.

Top module: `smb_cfg_target`

## Requirements
- R1: The target answers only the 7-bit address 1,1,0,1,0,`addr_sel`,0 (0x68 or 0x6A before the direction bit). It acknowledges a matching address byte. Any other address is not acknowledged, and no register changes until the next start.
- R2: A write is: address with direction bit 0, index N, count X, then X data bytes. Each of these bytes is acknowledged, and data byte k lands in register N+k.
- R3: A data byte that arrives after the X counted bytes is not acknowledged and not stored.
- R4: A read is: address+W, index N, repeated start, then address with direction bit 1. The target then returns the readback count (bits 4:0 of register 7, upper bits 0), followed by registers N, N+1, and so on, for as long as the host acknowledges.
- R5: A stop after any complete byte ends the transfer. Bytes already acknowledged stay written, and the next transfer starts normally.
- R6: The reset contents read back as follows: reg0=0xFF, reg1={spread_strap,6'b000110}, reg2=0xFF, reg3=0x5F, reg4=0x00, reg5=0x03, reg6=0x04, reg7=0x08.
- R7: Only these bits can be written: reg0[3:0], reg1[5:3], reg1[1:0], reg2[3:0], reg3[7:4] and reg7[4:0]. All other bits keep their fixed value. reg1[7:6] always shows `spread_strap`.
- R8: Indices 8 and above read 0x00, and writes to them change nothing.
- R9: The outputs follow the register fields: `pair_en`=reg0[3:0], `spread_sw_en`=reg1[5], `spread_sw_code`=reg1[4:3], `swing_code`=reg1[1:0], `pair_fast_slew`=reg2[3:0], `ref_slew_code`=reg3[7:6], `ref_wake_en`=reg3[5], `ref_en`=reg3[4].
- R10: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect. The target changes `sda_oe` only while SCL is low.
- R11: After the host does not acknowledge a read byte, the target keeps SDA released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 1 | Latched address-select strap |
| spread_strap | input | 2 | Latched spread code, shown in reg1[7:6] |
| pair_en | output | 4 | Per-pair output enables |
| pair_fast_slew | output | 4 | Per-pair slew select, 1 = fast |
| spread_sw_en | output | 1 | Software spread control enable |
| spread_sw_code | output | 2 | Software spread code |
| swing_code | output | 2 | Output amplitude code |
| ref_slew_code | output | 2 | Reference output slew code |
| ref_wake_en | output | 1 | Keep reference running in power-down |
| ref_en | output | 1 | Reference output enable |

## Verification
The bench builds the block with FILT_LEN=4 and two synchronizer stages. With these values a two-clock pulse on SCL is short enough to be rejected, yet a quarter bit of ten clocks leaves room for the target's acknowledge and data to settle before SCL rises. The bench then runs random block writes and readbacks over indices 0 to 9, so that the reserved and read-only masks and the dead indices above 7 are exercised. It also rewrites the count register and changes both straps, which moves the first read byte and the address that gets an acknowledge.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_HOLD
    } bus_state_e;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned REG_LAST    = 7;
    localparam logic [4:0]  ADDR_PREFIX = 5'b11010;
    localparam logic [7:0]  REV_VALUE   = 8'h03;
    localparam logic [7:0]  DEV_VALUE   = 8'h04;

endpackage

// File: rtl/smbcfg_line_filter.sv
module smbcfg_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;
    logic                   sync_w;

    assign sync_w = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_w == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            filt_q <= sync_w;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign line_o = filt_q;

    // R10: the filtered line only ever takes the value the synchronizer held
    assert_filter_follows_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(sync_w) == filt_q));

endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
    import smbcfg_pkg::*;
#(
    parameter int unsigned PAIRS   = 4,
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned CNT_RST = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    input  logic [1:0]         spread_strap,
    output logic [7:0]         rd_data,
    output logic [7:0]         rd_count,
    output logic [PAIRS-1:0]   pair_en,
    output logic [PAIRS-1:0]   pair_slew,
    output logic               sw_en,
    output logic [1:0]         sw_code,
    output logic [1:0]         swing,
    output logic [1:0]         ref_slew,
    output logic               ref_wake,
    output logic               ref_en
);
    localparam int unsigned PAD_W = BYTE_W - PAIRS;

    logic [PAIRS-1:0] en_q;
    logic [PAIRS-1:0] slew_q;
    logic             sw_en_q;
    logic [1:0]       sw_code_q;
    logic [1:0]       swing_q;
    logic [1:0]       ref_slew_q;
    logic             ref_wake_q;
    logic             ref_en_q;
    logic [CNT_W-1:0] cnt_q;

    logic wr0, wr1, wr2, wr3, wr7;
    assign wr0 = wr_en && (wr_idx == 8'd0);
    assign wr1 = wr_en && (wr_idx == 8'd1);
    assign wr2 = wr_en && (wr_idx == 8'd2);
    assign wr3 = wr_en && (wr_idx == 8'd3);
    assign wr7 = wr_en && (wr_idx == 8'd7);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[p]   <= 1'b1;
                slew_q[p] <= 1'b1;
            end else begin
                if (wr0) en_q[p]   <= wr_data[p];
                if (wr2) slew_q[p] <= wr_data[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en_q    <= 1'b0;
            sw_code_q  <= 2'b00;
            swing_q    <= 2'b10;
            ref_slew_q <= 2'b01;
            ref_wake_q <= 1'b0;
            ref_en_q   <= 1'b1;
            cnt_q      <= CNT_W'(CNT_RST);
        end else begin
            if (wr1) begin
                sw_en_q   <= wr_data[5];
                sw_code_q <= wr_data[4:3];
                swing_q   <= wr_data[1:0];
            end
            if (wr3) begin
                ref_slew_q <= wr_data[7:6];
                ref_wake_q <= wr_data[5];
                ref_en_q   <= wr_data[4];
            end
            if (wr7) cnt_q <= wr_data[CNT_W-1:0];
        end
    end

    always_comb begin
        case (rd_idx)
            8'd0:    rd_data = {{PAD_W{1'b1}}, en_q};
            8'd1:    rd_data = {spread_strap, sw_en_q, sw_code_q, 1'b1, swing_q};
            8'd2:    rd_data = {{PAD_W{1'b1}}, slew_q};
            8'd3:    rd_data = {ref_slew_q, ref_wake_q, ref_en_q, 4'hF};
            8'd5:    rd_data = REV_VALUE;
            8'd6:    rd_data = DEV_VALUE;
            8'd7:    rd_data = {{(BYTE_W-CNT_W){1'b0}}, cnt_q};
            default: rd_data = 8'h00;
        endcase
    end

    assign rd_count  = {{(BYTE_W-CNT_W){1'b0}}, cnt_q};
    assign pair_en   = en_q;
    assign pair_slew = slew_q;
    assign sw_en     = sw_en_q;
    assign sw_code   = sw_code_q;
    assign swing     = swing_q;
    assign ref_slew  = ref_slew_q;
    assign ref_wake  = ref_wake_q;
    assign ref_en    = ref_en_q;

    // R7: the count field moves only on a write aimed at index 7
    assert_count_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr7 |=> $stable(cnt_q));

    // R8: a write past the last index leaves the enables and the count alone
    assert_dead_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > 8'(REG_LAST))) |=> ($stable(en_q) && $stable(cnt_q)));

endmodule

// File: rtl/smbcfg_link.sv
module smbcfg_link
    import smbcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    input  logic [7:0] rd_count,
    output logic [7:0] rd_idx,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data
);
    bus_state_e st_q, st_d;
    logic       scl_d, sda_d;
    logic [7:0] shift_q, shift_d;
    logic [3:0] bit_q, bit_d;
    logic [7:0] idx_q, idx_d;
    logic [7:0] remain_q, remain_d;
    logic       dir_q, dir_d;
    logic       nak_q, nak_d;
    logic       oe_q, oe_d;
    logic       wr_en_q, wr_en_d;
    logic [7:0] wr_idx_q, wr_idx_d;
    logic [7:0] wr_data_q, wr_data_d;

    logic scl_rise, scl_fall, start_evt, stop_evt, byte_done;
    logic [6:0] my_addr;

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
    assign byte_done = scl_fall && (bit_q == 4'd8);
    assign my_addr   = {ADDR_PREFIX, addr_sel, 1'b0};

    always_comb begin
        st_d      = st_q;
        shift_d   = shift_q;
        bit_d     = bit_q;
        idx_d     = idx_q;
        remain_d  = remain_q;
        dir_d     = dir_q;
        nak_d     = nak_q;
        oe_d      = oe_q;
        wr_en_d   = 1'b0;
        wr_idx_d  = wr_idx_q;
        wr_data_d = wr_data_q;
        if (stop_evt) begin
            st_d = ST_IDLE;
            oe_d = 1'b0;
        end else if (start_evt) begin
            st_d  = ST_ADDR;
            bit_d = '0;
            oe_d  = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_HOLD: begin
                    oe_d = 1'b0;
                end
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && (bit_q != 4'd8)) begin
                        shift_d = {shift_q[6:0], sda_f};
                        bit_d   = bit_q + 1'b1;
                    end else if (byte_done) begin
                        unique case (st_q)
                            ST_ADDR: begin
                                if (shift_q[7:1] == my_addr) begin
                                    dir_d = shift_q[0];
                                    oe_d  = 1'b1;
                                    st_d  = ST_ADDR_ACK;
                                end else begin
                                    st_d = ST_HOLD;
                                end
                            end
                            ST_INDEX: begin
                                idx_d = shift_q;
                                oe_d  = 1'b1;
                                st_d  = ST_INDEX_ACK;
                            end
                            ST_COUNT: begin
                                remain_d = shift_q;
                                oe_d     = 1'b1;
                                st_d     = ST_COUNT_ACK;
                            end
                            default: begin
                                if (remain_q != 8'd0) begin
                                    wr_en_d   = 1'b1;
                                    wr_idx_d  = idx_q;
                                    wr_data_d = shift_q;
                                    idx_d     = idx_q + 1'b1;
                                    remain_d  = remain_q - 1'b1;
                                    oe_d      = 1'b1;
                                    st_d      = ST_WDATA_ACK;
                                end else begin
                                    st_d = ST_HOLD;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        oe_d  = 1'b0;
                        unique case (st_q)
                            ST_ADDR_ACK: begin
                                if (dir_q) begin
                                    shift_d = rd_count;
                                    oe_d    = ~rd_count[7];
                                    st_d    = ST_RDATA;
                                end else begin
                                    st_d = ST_INDEX;
                                end
                            end
                            ST_INDEX_ACK: st_d = ST_COUNT;
                            default:      st_d = ST_WDATA;
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_d = bit_q + 1'b1;
                    end else if (byte_done) begin
                        oe_d = 1'b0;
                        st_d = ST_RDATA_ACK;
                    end else if (scl_fall) begin
                        shift_d = {shift_q[6:0], 1'b0};
                        oe_d    = ~shift_q[6];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        nak_d = sda_f;
                    end else if (scl_fall) begin
                        bit_d = '0;
                        if (!nak_q) begin
                            shift_d = rd_data;
                            idx_d   = idx_q + 1'b1;
                            oe_d    = ~rd_data[7];
                            st_d    = ST_RDATA;
                        end else begin
                            st_d = ST_HOLD;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            shift_q  <= '0;
            bit_q    <= '0;
            idx_q    <= '0;
            remain_q <= '0;
            dir_q    <= 1'b0;
            nak_q    <= 1'b1;
        end else begin
            st_q     <= st_d;
            scl_d    <= scl_f;
            sda_d    <= sda_f;
            shift_q  <= shift_d;
            bit_q    <= bit_d;
            idx_q    <= idx_d;
            remain_q <= remain_d;
            dir_q    <= dir_d;
            nak_q    <= nak_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            oe_q      <= oe_d;
            wr_en_q   <= wr_en_d;
            wr_idx_q  <= wr_idx_d;
            wr_data_q <= wr_data_d;
        end
    end

    assign rd_idx  = idx_q;
    assign sda_oe  = oe_q;
    assign wr_en   = wr_en_q;
    assign wr_idx  = wr_idx_q;
    assign wr_data = wr_data_q;

    // R10: the target moves SDA only while the filtered SCL is low
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !scl_f);

    // R3: a stored byte always consumed part of a nonzero count
    assert_write_within_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> ($past(remain_q) != 8'd0));

    // R11 and R1: while waiting for the next start the line stays released
    assert_hold_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |-> !oe_q);

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smbcfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned PAIRS       = 4,
    parameter int unsigned CNT_W       = 5,
    parameter int unsigned CNT_RST     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_sel,
    input  logic [1:0]       spread_strap,
    output logic [PAIRS-1:0] pair_en,
    output logic [PAIRS-1:0] pair_fast_slew,
    output logic             spread_sw_en,
    output logic [1:0]       spread_sw_code,
    output logic [1:0]       swing_code,
    output logic [1:0]       ref_slew_code,
    output logic             ref_wake_en,
    output logic             ref_en
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw_w, filt_w;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data, rd_count;

    assign raw_w = {sda_i, scl_i};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        smbcfg_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[l]),
            .line_o (filt_w[l])
        );
    end

    smbcfg_link i_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_w[0]),
        .sda_f    (filt_w[1]),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .rd_count (rd_count),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    smbcfg_regs #(
        .PAIRS   (PAIRS),
        .CNT_W   (CNT_W),
        .CNT_RST (CNT_RST)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .rd_idx       (rd_idx),
        .spread_strap (spread_strap),
        .rd_data      (rd_data),
        .rd_count     (rd_count),
        .pair_en      (pair_en),
        .pair_slew    (pair_fast_slew),
        .sw_en        (spread_sw_en),
        .sw_code      (spread_sw_code),
        .swing        (swing_code),
        .ref_slew     (ref_slew_code),
        .ref_wake     (ref_wake_en),
        .ref_en       (ref_en)
    );

endmodule

// File: tb/test_smb_cfg_target.sv
module test_smb_cfg_target;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic [1:0] spread_strap = 2'b01;
    logic sda_line;
    logic sda_oe;
    logic [3:0] pair_en, pair_fast_slew;
    logic spread_sw_en, ref_wake_en, ref_en;
    logic [1:0] spread_sw_code, swing_code, ref_slew_code;

    int n_checks = 0;
    int n_fail = 0;
    int oe_violations = 0;
    bit finished = 0;
    bit glitch_on = 0;
    logic [7:0] mregs [8];
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    smb_cfg_target #(.SYNC_STAGES(2), .FILT_LEN(4)) i_smb_cfg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .spread_strap(spread_strap), .pair_en(pair_en),
        .pair_fast_slew(pair_fast_slew), .spread_sw_en(spread_sw_en),
        .spread_sw_code(spread_sw_code), .swing_code(swing_code),
        .ref_slew_code(ref_slew_code), .ref_wake_en(ref_wake_en), .ref_en(ref_en));

    // R10 monitor: sda_oe must not move while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && (sda_oe !== oe_prev)) oe_violations++;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] idx);
        case (idx)
            8'd0:    return {4'hF, mregs[0][3:0]};
            8'd1:    return {spread_strap, mregs[1][5:3], 1'b1, mregs[1][1:0]};
            8'd2:    return {4'hF, mregs[2][3:0]};
            8'd3:    return {mregs[3][7:4], 4'hF};
            8'd5:    return 8'h03;
            8'd6:    return 8'h04;
            8'd7:    return {3'b000, mregs[7][4:0]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [6:0] my_addr();
        return {5'b11010, addr_sel, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b1; waitq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            if (glitch_on && i == 3) begin
                m_scl = 1'b1; waitq(2); m_scl = 1'b0;
            end
            waitq(Q);
            m_scl = 1'b1; waitq(2 * Q);
            m_scl = 1'b0; waitq(Q);
        end
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        acked = (sda_line == 1'b0);
        waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic rbyte(input logic ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitq(Q);
            m_scl = 1'b1; waitq(Q);
            b[i] = sda_line;
            waitq(Q);
            m_scl = 1'b0;
        end
        waitq(Q);
        m_sda = ~ack; waitq(Q);
        m_scl = 1'b1; waitq(2 * Q);
        m_scl = 1'b0; waitq(Q);
        m_sda = 1'b1;
    endtask

    // block write: cnt announced, nsend data bytes sent (stops after a NAK)
    task automatic do_write(input logic [7:0] idx, input int cnt, input int nsend, input string tag);
        logic a;
        bus_start();
        wbyte({my_addr(), 1'b0}, a); check({tag, " R1 address ack"}, a, 1'b1);
        wbyte(idx, a);               check({tag, " R2 index ack"}, a, 1'b1);
        wbyte(8'(cnt), a);           check({tag, " R2 count ack"}, a, 1'b1);
        for (int k = 0; k < nsend; k++) begin
            wbyte(wbuf[k], a);
            if (k < cnt) begin
                check({tag, " R2 data ack"}, a, 1'b1);
                if ((32'(idx) + k) < 8) mregs[idx + 8'(k)] = wbuf[k];
            end else begin
                check({tag, " R3 surplus byte nak"}, a, 1'b0);
                break;
            end
        end
        bus_stop();
        waitq(Q);
    endtask

    task automatic do_read(input logic [7:0] idx, input int n, input string tag);
        logic a;
        logic [7:0] b;
        bus_start();
        wbyte({my_addr(), 1'b0}, a); check({tag, " R4 address ack"}, a, 1'b1);
        wbyte(idx, a);               check({tag, " R4 index ack"}, a, 1'b1);
        bus_rstart();
        wbyte({my_addr(), 1'b1}, a); check({tag, " R4 read address ack"}, a, 1'b1);
        rbyte(n > 0, b);             check({tag, " R4 count byte"}, b, exp_rd(8'd7));
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, b);
            check({tag, " R4 data byte"}, b, exp_rd(idx + 8'(k)));
        end
        waitq(2 * Q);
        check({tag, " R11 released after nak"}, sda_oe, 1'b0);
        bus_stop();
        waitq(Q);
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R9 pair_en"}, pair_en, mregs[0][3:0]);
        check({tag, " R9 slew"}, pair_fast_slew, mregs[2][3:0]);
        check({tag, " R9 spread"}, {spread_sw_en, spread_sw_code}, mregs[1][5:3]);
        check({tag, " R9 swing"}, swing_code, mregs[1][1:0]);
        check({tag, " R9 ref"}, {ref_slew_code, ref_wake_en, ref_en}, mregs[3][7:4]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic a;
        void'($urandom(32'd4711));
        mregs[0] = 8'h0F; mregs[1] = 8'h02; mregs[2] = 8'h0F; mregs[3] = 8'h50;
        mregs[4] = 8'h00; mregs[5] = 8'h03; mregs[6] = 8'h04; mregs[7] = 8'h08;
        waitq(5);
        rst_n = 1'b1;
        waitq(5);

        // R6: reset state at the ports and through a full readback
        check("R6 sda released", sda_oe, 1'b0);
        check_outputs("R6 reset");
        do_read(8'd0, 8, "R6 reset readback");

        // R1: wrong address gets no ack and writes nothing
        bus_start();
        wbyte(8'hD4, a); check("R1 foreign address nak", a, 1'b0);
        wbyte(8'h00, a); check("R1 ignored byte nak", a, 1'b0);
        bus_stop();
        check_outputs("R1 after foreign");

        // R3: surplus byte refused
        wbuf[0] = 8'h05; wbuf[1] = 8'hA3; wbuf[2] = 8'h00;
        do_write(8'd0, 2, 3, "R3 surplus");
        do_read(8'd0, 3, "R3 readback");
        check_outputs("R3");

        // R5: stop after one data byte of four
        wbuf[0] = 8'h0A;
        do_write(8'd2, 4, 1, "R5 early stop");
        do_read(8'd0, 4, "R5 readback");

        // R7: read-only and reserved bits, strap follows
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'hFF; wbuf[3] = 8'h00;
        do_write(8'd3, 4, 4, "R7 read-only");
        spread_strap = 2'b11;
        do_read(8'd1, 7, "R7 readback");

        // R8: beyond the last index
        wbuf[0] = 8'h5A; wbuf[1] = 8'h5A;
        do_write(8'd8, 2, 2, "R8 dead write");
        do_read(8'd7, 3, "R8 dead read");
        check_outputs("R8");

        // R4: count register change moves the first read byte
        wbuf[0] = 8'h13;
        do_write(8'd7, 1, 1, "R4 count");
        do_read(8'd6, 2, "R4 new count");

        // R10: SCL glitch inside a write
        glitch_on = 1;
        wbuf[0] = 8'h06;
        do_write(8'd0, 1, 1, "R10 glitch");
        glitch_on = 0;
        do_read(8'd0, 1, "R10 readback");

        // R1: other strap value
        addr_sel = 1'b1;
        bus_start();
        wbyte(8'hD0, a); check("R1 old address now nak", a, 1'b0);
        bus_stop();
        wbuf[0] = 8'h21;
        do_write(8'd1, 1, 1, "R1 strap high");
        check_outputs("R1 strap high");

        // random block transfers
        for (int it = 0; it < 14; it++) begin
            logic [7:0] idx;
            int cnt;
            idx = 8'($urandom_range(0, 9));
            cnt = $urandom_range(1, 4);
            for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
            do_write(idx, cnt, cnt, "R2 random write");
            do_read(idx, cnt, "R2 random read");
            check_outputs("R9 random");
        end

        check("R10 no SDA change with SCL high", oe_violations, 0);
        summary();
    end
endmodule